// File: doc/BRIEF.md
# I2C Bus Timeout Supervisor

This block watches a target-side I2C bus for clock-low conditions that last too long and, when one is found, emits a one-cycle pulse that resets the target's communication logic. It takes a synchronised SCL and SDA, a flag that is high while the target itself is holding SCL low, an 8-bit mode code, and a timebase tick. The tick is nominally one per millisecond. All limits are counted in ticks.

The mode code selects the active limits. Code 0x1E is standard speed with timeouts. It enforces a per-low-phase limit of 30 ticks, a cumulative target-stretch budget of 25 ticks and a cumulative controller-low budget of 10 ticks. Code 0x09 is fast speed with timeouts and enforces only a per-low-phase limit of 10 ticks. A stuck-low limit of 2000 ticks applies under every code. Any other code enables nothing else.

The cumulative budgets cover one transaction. They restart on a Start condition or a Stop condition. After a pulse, the block stays silent until SCL has been seen high.

Top module: `i2c_tmo_supervisor`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, if_rst_o is 0.
- R2: With mode_i = 0x1E, a single SCL low phase reaching 30 ticks fires a pulse. The ticks count whatever the stretch flag is during that phase.
- R3: With mode_i = 0x1E, ticks seen while SCL is low and tgt_stretch_i = 1 add to a target budget. The budget is summed across low phases, and a pulse fires on the 25th tick.
- R4: With mode_i = 0x1E, ticks seen while SCL is low and tgt_stretch_i = 0 add to a controller budget. The budget is summed across low phases, and a pulse fires on the 10th tick.
- R5: With mode_i = 0x09, a single low phase reaching 10 ticks fires a pulse, and the cumulative budgets are not applied.
- R6: Under any mode code, 2000 ticks in one SCL low phase fire a pulse. Under a code other than 0x1E or 0x09, nothing else fires.
- R7: The per-phase and stuck-low counts restart from zero whenever scl_i is 1.
- R8: The cumulative budgets restart on a Start condition (sda_i falls while scl_i stays 1) and on a Stop condition (sda_i rises while scl_i stays 1).
- R9: A pulse is exactly one cycle wide. It appears in the cycle after the clock edge that samples the tick reaching the limit.
- R10: After a pulse, all counts are cleared and further ticks while SCL stays low produce no pulse. Counting resumes from zero once scl_i has been 1.
- R11: Only cycles with tick_i = 1 while scl_i = 0 advance any count. Elapsed clock cycles alone, and ticks while SCL is high, never cause a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level, used for Start/Stop detection |
| tgt_stretch_i | input | 1 | High while the target holds SCL low |
| mode_i | input | 8 | Mode code selecting speed and timeout enables |
| tick_i | input | 1 | Timebase tick, one clock cycle wide |
| if_rst_o | output | 1 | One-cycle reset pulse to the communication logic |

## Verification
A wrong count or a mis-routed stretch flag shows at if_rst_o as a pulse one tick early, one tick late, or missing, in the cycle after the tick that should reach the limit. The bench therefore checks the output after every tick of each low phase, not only at the end. A budget that fails to restart on Start, Stop or SCL high shows up as a premature pulse in the next phase. A broken lockout shows up as a second pulse while SCL is still held low.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  typedef enum logic [1:0] {SPD_OFF, SPD_STD, SPD_FAST} spd_e;

  localparam logic [7:0] MODE_STD_TMO  = 8'h1E;
  localparam logic [7:0] MODE_FAST_TMO = 8'h09;

  localparam int NCNT    = 4;
  localparam int C_PHASE = 0;
  localparam int C_TGT   = 1;
  localparam int C_CTL   = 2;
  localparam int C_STUCK = 3;

  function automatic spd_e decode_mode(logic [7:0] m);
    if (m == MODE_STD_TMO)  return SPD_STD;
    if (m == MODE_FAST_TMO) return SPD_FAST;
    return SPD_OFF;
  endfunction
endpackage

// File: rtl/i2c_tmo_cond.sv
// Start/Stop detection from synchronised bus levels
module i2c_tmo_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tmo_cnt.sv
// Tick counter with clear priority and runtime limit
module i2c_tmo_cnt #(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] lim_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  // >= keeps a limit reachable if a runtime limit drops below the count
  assign hit_o  = inc_i && (lim_i != '0) && (cnt_nx >= {1'b0, lim_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !cnt_nx[CW]) cnt_q <= cnt_nx[CW-1:0];
  end
endmodule

// File: rtl/i2c_tmo_supervisor.sv
module i2c_tmo_supervisor
  import i2c_tmo_pkg::*;
#(
  parameter int LIM_STD   = 30,
  parameter int LIM_FAST  = 10,
  parameter int BUD_TGT   = 25,
  parameter int BUD_CTL   = 10,
  parameter int LIM_STUCK = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       tgt_stretch_i,
  input  logic [7:0] mode_i,
  input  logic       tick_i,
  output logic       if_rst_o
);
  localparam int LMAX1 = (LIM_STD > LIM_FAST) ? LIM_STD : LIM_FAST;
  localparam int LMAX2 = (BUD_TGT > BUD_CTL) ? BUD_TGT : BUD_CTL;
  localparam int LMAX3 = (LMAX1 > LMAX2) ? LMAX1 : LMAX2;
  localparam int LMAX  = (LMAX3 > LIM_STUCK) ? LMAX3 : LIM_STUCK;
  localparam int CW    = $clog2(LMAX + 1);

  spd_e          spd;
  logic          start, stop;
  logic          armed_q, pulse_q;
  logic          tick_low, fire, xact_clr;
  logic [NCNT-1:0] inc, clr, hit;
  logic [CW-1:0] lim [NCNT];

  assign spd = decode_mode(mode_i);

  i2c_tmo_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .start_o(start),
    .stop_o (stop)
  );

  assign tick_low = tick_i & ~scl_i & armed_q;
  assign xact_clr = start | stop;

  always_comb begin
    inc[C_PHASE] = tick_low & (spd != SPD_OFF);
    inc[C_TGT]   = tick_low & (spd == SPD_STD) & tgt_stretch_i;
    inc[C_CTL]   = tick_low & (spd == SPD_STD) & ~tgt_stretch_i;
    inc[C_STUCK] = tick_low;

    clr[C_PHASE] = scl_i | fire;
    clr[C_TGT]   = xact_clr | fire;
    clr[C_CTL]   = xact_clr | fire;
    clr[C_STUCK] = scl_i | fire;

    lim[C_PHASE] = (spd == SPD_FAST) ? CW'(LIM_FAST) : CW'(LIM_STD);
    lim[C_TGT]   = CW'(BUD_TGT);
    lim[C_CTL]   = CW'(BUD_CTL);
    lim[C_STUCK] = CW'(LIM_STUCK);
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    i2c_tmo_cnt #(.CW(CW)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr[g]),
      .inc_i (inc[g]),
      .lim_i (lim[g]),
      .hit_o (hit[g])
    );
  end

  assign fire = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire)       armed_q <= 1'b0;
      else if (scl_i) armed_q <= 1'b1;
    end
  end

  assign if_rst_o = pulse_q;
endmodule

// File: rtl/i2c_tmo_sva.sv
module i2c_tmo_sva #(
  parameter int LIM_STUCK = 2000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       tick_i,
  input logic [7:0] mode_i,
  input logic       if_rst_o
);
  int   lt_q;
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lt_q     <= 0;
      locked_q <= 1'b0;
    end else begin
      if (scl_i || if_rst_o)  lt_q <= 0;
      else if (tick_i)        lt_q <= lt_q + 1;
      if (if_rst_o)           locked_q <= 1'b1;
      else if (scl_i)         locked_q <= 1'b0;
    end
  end

  // R9
  p_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |=> !if_rst_o);

  // R11
  p_needs_low_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |-> ($past(tick_i) && !$past(scl_i)));

  // R10
  p_lockout_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |-> !locked_q);

  // R6
  p_off_only_stuck_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_rst_o && $past(mode_i) != 8'h1E && $past(mode_i) != 8'h09) |-> (lt_q >= LIM_STUCK));
endmodule

bind i2c_tmo_supervisor i2c_tmo_sva #(.LIM_STUCK(LIM_STUCK)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .tick_i  (tick_i),
  .mode_i  (mode_i),
  .if_rst_o(if_rst_o)
);

// File: tb/sim_i2c_tmo_supervisor.sv
`timescale 1ns/1ps
module sim_i2c_tmo_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, stretch = 1'b0, tick = 1'b0;
  logic [7:0] mode = 8'h1E;
  logic       pulse;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_tmo_supervisor u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .tgt_stretch_i(stretch), .mode_i(mode), .tick_i(tick), .if_rst_o(pulse)
  );

  typedef struct packed {
    logic [7:0]  mode;
    logic        str;
    logic [11:0] n;
    logic [11:0] at;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h1E, 1'b0, 12'd10, 12'd10},  // R4
    '{8'h1E, 1'b1, 12'd25, 12'd25},  // R3
    '{8'h09, 1'b0, 12'd10, 12'd10},  // R5
    '{8'h09, 1'b1, 12'd9,  12'd0 },  // R5
    '{8'h00, 1'b0, 12'd40, 12'd0 },  // R6
    '{8'h1E, 1'b0, 12'd9,  12'd0 }   // R4
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // n ticks; pulse expected only after tick number 'at' (0 = never)
  task automatic run_ticks(input int n, input int at, input string tag);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      check(pulse == (i == at), tag, pulse, (i == at));
    end
  endtask

  task automatic go_low;
    @(negedge clk) scl = 1'b0;
  endtask

  task automatic blip_high;
    @(negedge clk) scl = 1'b1;
    @(negedge clk) scl = 1'b0;
  endtask

  task automatic bus_stop;
    @(negedge clk) sda = 1'b0;
    @(negedge clk) scl = 1'b1;
    @(negedge clk) sda = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_start;
    @(negedge clk) scl = 1'b1;
    @(negedge clk) sda = 1'b0;
    @(negedge clk) scl = 1'b0;
    @(negedge clk) sda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R1 in reset", pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse == 1'b0, "R1 after reset", pulse, 0);

    for (int v = 0; v < NV; v++) begin
      mode = VECS[v].mode;
      stretch = VECS[v].str;
      go_low();
      run_ticks(int'(VECS[v].n), int'(VECS[v].at), $sformatf("vector %0d", v));
      bus_stop();
    end

    // R2: one phase of 21 stretched + 9 controller ticks hits the 30 limit
    mode = 8'h1E; stretch = 1'b1; go_low();
    run_ticks(21, 0, "R2 part a");
    stretch = 1'b0;
    run_ticks(9, 9, "R2 part b");
    bus_stop();

    // R3: target budget sums across phases
    stretch = 1'b1; go_low();
    run_ticks(15, 0, "R3 phase1");
    blip_high();
    run_ticks(10, 10, "R3 phase2");
    bus_stop();

    // R4: controller budget sums across phases
    stretch = 1'b0; go_low();
    run_ticks(5, 0, "R4 phase1");
    blip_high();
    run_ticks(5, 5, "R4 phase2");
    bus_stop();

    // R8: Start clears budgets
    go_low();
    run_ticks(6, 0, "R8 before start");
    bus_start();
    run_ticks(6, 0, "R8 after start");
    run_ticks(4, 4, "R8 budget from start");
    bus_stop();

    // R8: Stop clears budgets
    go_low();
    run_ticks(9, 0, "R8 before stop");
    bus_stop();
    go_low();
    run_ticks(1, 0, "R8 after stop");
    run_ticks(9, 9, "R8 budget from stop");
    bus_stop();

    // R7 / R5: fast-mode phase limit restarts on SCL high; no budgets
    mode = 8'h09; go_low();
    for (int k = 0; k < 4; k++) begin
      run_ticks(9, 0, "R7 fast phases");
      blip_high();
    end
    bus_stop();

    // R9 / R10: pulse width and lockout
    go_low();
    run_ticks(10, 10, "R10 first pulse");
    @(negedge clk);
    check(pulse == 1'b0, "R9 width", pulse, 0);
    run_ticks(20, 0, "R10 locked");
    blip_high();
    run_ticks(10, 10, "R10 rearmed");
    bus_stop();

    // R6: stuck-low in a mode without timeouts
    mode = 8'h00; go_low();
    run_ticks(2000, 2000, "R6 stuck");
    bus_stop();

    // R11: cycles without ticks, and ticks while SCL high
    mode = 8'h09; go_low();
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      check(pulse == 1'b0, "R11 no tick", pulse, 0);
    end
    @(negedge clk) scl = 1'b1;
    run_ticks(30, 0, "R11 ticks high");
    go_low();
    run_ticks(10, 10, "R11 counts from zero");
    bus_stop();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule